// File: doc/BRIEF.md
# Two-Way Word Mailbox with End-of-Transfer Marking

The block couples a host that talks through a small address/data register port with a controller that moves words as valid/ready streams. Two independent eight-entry queues of 32-bit words sit between them. The outbound queue runs from host to controller, and the return queue runs from controller to host. Each stored word carries an end-of-transfer flag and a parity bit. The host fills the outbound queue by register writes. It closes a message by writing a marker entry that carries the flag. The controller drains this queue as a stream. The controller fills the return queue as a stream, and the host drains it by register reads.

Each queue has one packed status word. It reports fill level, full and empty, a valid map and a flag map that are indexed from the oldest entry, a sticky "flagged entry consumed" bit, a sticky parity-error bit, and two sticky reset-request bits. One request bit comes from the host and one from the controller.

Stream rules: `up_valid` is high whenever the outbound queue holds a word. While `up_valid` is high and `up_ready` is low, `up_data` and `up_eot` hold still. A word leaves on a clock edge where both are high. On the return side, `dn_ready` is high whenever the return queue has room. A word is taken on a clock edge where `dn_valid` and `dn_ready` are both high. The register port acts on the clock edge where `reg_wr` or `reg_rd` is high. `reg_rdata` follows `reg_addr` combinationally. Only one of `reg_wr` and `reg_rd` may be high in a cycle.

Top module: `duplex_mailbox`

## Requirements
- R1: A write to offset 0x00 appends `reg_wdata` with its flag clear to the outbound queue. The controller receives words on `up_data`/`up_eot` in first-in first-out order.
- R2: The controller's words enter the return queue in order. A read of offset 0x40 returns the oldest word and removes it. When the queue is empty, the read returns 0 and leaves the queue unchanged.
- R3: The status words are read at offset 0x04 (outbound) and 0x44 (return). In each, bit 21 is full, bit 20 is empty and bits 19:16 are the entry count. Bits 31:30, 28:26 and 22 always read 0.
- R4: In each status word, bit 8+i is set exactly when entry i exists, where entry 0 is the oldest. Bit i is that entry's end-of-transfer flag.
- R5: A write to offset 0x08 with bit 31 set appends a marker entry with data 0 and the flag set. The same write with bit 31 clear changes nothing.
- R6: A full queue takes no new word. A write to 0x00 or 0x08 is dropped while the outbound queue is full. `dn_ready` is low while the return queue is full.
- R7: Status bit 23 becomes set when a flagged entry leaves its queue. It stays set until acknowledged. On the return side, the acknowledge is a write of bit 31 to offset 0x54. On the outbound side, it is a pulse on `ctl_up_eot_ack`. A reset of that queue also clears it.
- R8: A write of bit 31 to offset 0x0C sets bit 25 in both status words and raises `host_rst_req`. A pulse on `ctl_rst_req` sets bit 24 in both status words.
- R9: A pulse on `ctl_up_flush` empties the outbound queue. A write of bit 31 to offset 0x50 empties the return queue. Either reset clears that queue's bits 29, 25, 24 and 23.
- R10: Each entry keeps even parity over its data, computed when it is stored. Status bit 29 becomes set only when an entry leaves with a parity mismatch, so it stays 0 for intact storage.
- R11: While `up_valid` is high and `up_ready` is low, `up_data` and `up_eot` stay unchanged in the next cycle, unless `ctl_up_flush` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (removes a word at 0x40) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| up_valid | output | 1 | Outbound stream word available |
| up_ready | input | 1 | Controller accepts outbound word |
| up_data | output | 32 | Outbound stream word |
| up_eot | output | 1 | Outbound word carries end-of-transfer |
| dn_valid | input | 1 | Return stream word offered |
| dn_ready | output | 1 | Return queue has room |
| dn_data | input | 32 | Return stream word |
| dn_eot | input | 1 | Return word carries end-of-transfer |
| ctl_rst_req | input | 1 | Controller reset-request pulse |
| ctl_up_flush | input | 1 | Controller empties the outbound queue |
| ctl_up_eot_ack | input | 1 | Controller acknowledges a consumed outbound flag |
| host_rst_req | output | 1 | Host reset request pending on the outbound queue |

## Verification
Directed sequences first drive each queue through empty, partly filled, exactly full and overfull. These separate a dropped word from a wrapped pointer and from a miscounted fill level. The runs interleave flagged and unflagged words, including marker writes with bit 31 clear, so that the flag map, which is indexed from the oldest entry, can be told apart from a map indexed by physical slot. A seeded random mix then interleaves host writes, host reads, stream transfers, stalls, acknowledges, requests and resets. After every operation a bench model predicts each status word, the stream heads and the read data. This exposes ordering or sticky-bit errors that appear only after the pointers wrap.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [7:0] OFS_UP_DATA = 8'h00;
  localparam logic [7:0] OFS_UP_STAT = 8'h04;
  localparam logic [7:0] OFS_UP_MARK = 8'h08;
  localparam logic [7:0] OFS_UP_RREQ = 8'h0C;
  localparam logic [7:0] OFS_DN_DATA = 8'h40;
  localparam logic [7:0] OFS_DN_STAT = 8'h44;
  localparam logic [7:0] OFS_DN_RST  = 8'h50;
  localparam logic [7:0] OFS_DN_ACK  = 8'h54;
  localparam int         MAP_W       = 8;

  typedef struct packed {
    logic             perr;
    logic             hreq;
    logic             creq;
    logic             deot;
    logic             full;
    logic             empty;
    logic [3:0]       cnt;
    logic [MAP_W-1:0] vmap;
    logic [MAP_W-1:0] emap;
  } q_stat_t;

  function automatic logic [31:0] pack_stat(input q_stat_t s);
    logic [31:0] w;
    w        = '0;
    w[29]    = s.perr;
    w[25]    = s.hreq;
    w[24]    = s.creq;
    w[23]    = s.deot;
    w[21]    = s.full;
    w[20]    = s.empty;
    w[19:16] = s.cnt;
    w[15:8]  = s.vmap;
    w[7:0]   = s.emap;
    return w;
  endfunction
endpackage

// File: rtl/mbx_queue.sv
module mbx_queue
  import mbx_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         push_eot,
  input  logic         pop,
  input  logic         set_hreq,
  input  logic         set_creq,
  input  logic         eot_ack,
  output logic [W-1:0] head_data,
  output logic         head_eot,
  output logic         full,
  output logic         empty,
  output logic [31:0]  status
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = W + 2;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          perr_q, hreq_q, creq_q, deot_q;
  logic          head_par, do_push, do_pop;
  logic [MAP_W-1:0] vmap, emap;
  q_stat_t       st;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign {head_par, head_eot, head_data} = mem[rd_ptr];
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= {^push_data, push_eot, push_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0; wr_ptr <= '0; cnt <= '0;
      perr_q <= 1'b0; hreq_q <= 1'b0; creq_q <= 1'b0; deot_q <= 1'b0;
    end else if (flush) begin
      rd_ptr <= '0; wr_ptr <= '0; cnt <= '0;
      perr_q <= 1'b0; hreq_q <= 1'b0; creq_q <= 1'b0; deot_q <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
      if (do_pop && ((^head_data) != head_par)) perr_q <= 1'b1;
      if (set_hreq) hreq_q <= 1'b1;
      if (set_creq) creq_q <= 1'b1;
      if (do_pop && head_eot)  deot_q <= 1'b1;
      else if (eot_ack)        deot_q <= 1'b0;
    end
  end

  always_comb begin
    vmap = '0;
    emap = '0;
    for (int i = 0; i < MAP_W; i++) begin
      if (i < DEPTH && i < int'(cnt)) begin
        vmap[i] = 1'b1;
        emap[i] = mem[AW'((int'(rd_ptr) + i) % DEPTH)][W];
      end
    end
  end

  always_comb begin
    st       = '0;
    st.perr  = perr_q;
    st.hreq  = hreq_q;
    st.creq  = creq_q;
    st.deot  = deot_q;
    st.full  = full;
    st.empty = empty;
    st.cnt   = 4'(cnt);
    st.vmap  = vmap;
    st.emap  = emap;
  end

  assign status = pack_stat(st);
endmodule

// File: rtl/mbx_host_port.sv
module mbx_host_port
  import mbx_pkg::*;
#(
  parameter int AW_REG = 8,
  parameter int W      = 32
) (
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW_REG-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  input  logic [31:0]       up_status,
  input  logic [31:0]       dn_status,
  input  logic [W-1:0]      dn_head,
  input  logic              dn_empty,
  output logic              up_push,
  output logic [W-1:0]      up_push_data,
  output logic              up_push_eot,
  output logic              host_req,
  output logic              dn_pop,
  output logic              dn_flush,
  output logic              dn_ack,
  output logic [31:0]       reg_rdata
);
  logic hit_data, hit_mark;
  assign hit_data = reg_wr && (reg_addr == AW_REG'(OFS_UP_DATA));
  assign hit_mark = reg_wr && (reg_addr == AW_REG'(OFS_UP_MARK)) && reg_wdata[W-1];

  assign up_push      = hit_data || hit_mark;
  assign up_push_data = hit_mark ? '0 : reg_wdata;
  assign up_push_eot  = hit_mark;
  assign host_req     = reg_wr && (reg_addr == AW_REG'(OFS_UP_RREQ)) && reg_wdata[W-1];
  assign dn_flush     = reg_wr && (reg_addr == AW_REG'(OFS_DN_RST))  && reg_wdata[W-1];
  assign dn_ack       = reg_wr && (reg_addr == AW_REG'(OFS_DN_ACK))  && reg_wdata[W-1];
  assign dn_pop       = reg_rd && (reg_addr == AW_REG'(OFS_DN_DATA));

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW_REG'(OFS_UP_STAT))      reg_rdata = up_status;
    else if (reg_addr == AW_REG'(OFS_DN_STAT)) reg_rdata = dn_status;
    else if (reg_addr == AW_REG'(OFS_DN_DATA)) reg_rdata = dn_empty ? '0 : 32'(dn_head);
  end
endmodule

// File: rtl/duplex_mailbox.sv
module duplex_mailbox #(
  parameter int AW_REG = 8,
  parameter int W      = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW_REG-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              up_valid,
  input  logic              up_ready,
  output logic [W-1:0]      up_data,
  output logic              up_eot,
  input  logic              dn_valid,
  output logic              dn_ready,
  input  logic [W-1:0]      dn_data,
  input  logic              dn_eot,
  input  logic              ctl_rst_req,
  input  logic              ctl_up_flush,
  input  logic              ctl_up_eot_ack,
  output logic              host_rst_req
);
  logic [31:0]  up_status, dn_status;
  logic [W-1:0] up_push_data, dn_head;
  logic         up_push, up_push_eot, host_req, dn_pop, dn_flush, dn_ack;
  logic         up_full, up_empty, dn_full, dn_empty, dn_head_eot;

  mbx_host_port #(.AW_REG(AW_REG), .W(W)) u_port (
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .up_status(up_status), .dn_status(dn_status), .dn_head(dn_head), .dn_empty(dn_empty),
    .up_push(up_push), .up_push_data(up_push_data), .up_push_eot(up_push_eot),
    .host_req(host_req), .dn_pop(dn_pop), .dn_flush(dn_flush), .dn_ack(dn_ack),
    .reg_rdata(reg_rdata)
  );

  mbx_queue #(.W(W), .DEPTH(DEPTH)) u_upq (
    .clk(clk), .rst_n(rst_n), .flush(ctl_up_flush),
    .push(up_push), .push_data(up_push_data), .push_eot(up_push_eot),
    .pop(up_ready), .set_hreq(host_req), .set_creq(ctl_rst_req), .eot_ack(ctl_up_eot_ack),
    .head_data(up_data), .head_eot(up_eot), .full(up_full), .empty(up_empty),
    .status(up_status)
  );

  mbx_queue #(.W(W), .DEPTH(DEPTH)) u_dnq (
    .clk(clk), .rst_n(rst_n), .flush(dn_flush),
    .push(dn_valid), .push_data(dn_data), .push_eot(dn_eot),
    .pop(dn_pop), .set_hreq(host_req), .set_creq(ctl_rst_req), .eot_ack(dn_ack),
    .head_data(dn_head), .head_eot(dn_head_eot), .full(dn_full), .empty(dn_empty),
    .status(dn_status)
  );

  assign up_valid     = !up_empty;
  assign dn_ready     = !dn_full;
  assign host_rst_req = up_status[25];

  logic unused_ok;
  assign unused_ok = ^{up_full, dn_head_eot};
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int AW_REG = 8,
  parameter int W      = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [AW_REG-1:0] reg_addr,
  input logic [W-1:0]      reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              up_valid,
  input logic              up_ready,
  input logic [W-1:0]      up_data,
  input logic              up_eot,
  input logic              dn_ready,
  input logic              ctl_up_flush,
  input logic [31:0]       up_status,
  input logic [31:0]       dn_status
);
  localparam logic [31:0] RSV_MASK = 32'hDC40_0000;

  a_r3_full_empty_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_status[21] && up_status[20]) && !(dn_status[21] && dn_status[20]));

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((up_status & RSV_MASK) == '0) && ((dn_status & RSV_MASK) == '0));

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (up_status[19:16] <= 4'd8) && (dn_status[19:16] <= 4'd8));

  a_r6_no_room_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    dn_status[21] |-> !dn_ready);

  a_r2_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_status[20] && reg_addr == AW_REG'(8'h40)) |-> (reg_rdata == '0));

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW_REG'(8'h54) && reg_wdata[W-1]) |=> !dn_status[23]);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_up_flush |=> (up_status[20] && !up_valid && up_status[25:23] == 3'b000));

  a_r11_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_ready && !ctl_up_flush) |=> (up_valid && $stable(up_data) && $stable(up_eot)));
endmodule

bind duplex_mailbox mbx_checker #(.AW_REG(AW_REG), .W(W)) u_mbx_checker (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
  .up_eot(up_eot), .dn_ready(dn_ready), .ctl_up_flush(ctl_up_flush),
  .up_status(up_status), .dn_status(dn_status)
);

// File: tb/test_duplex_mailbox.sv
module test_duplex_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        up_valid, up_ready = 0, up_eot;
  logic [31:0] up_data;
  logic        dn_valid = 0, dn_ready, dn_eot = 0;
  logic [31:0] dn_data = 0;
  logic        ctl_rst_req = 0, ctl_up_flush = 0, ctl_up_eot_ack = 0, host_rst_req;

  always #10 clk = ~clk;

  duplex_mailbox i_duplex_mailbox (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .up_valid(up_valid), .up_ready(up_ready),
    .up_data(up_data), .up_eot(up_eot), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_data(dn_data), .dn_eot(dn_eot), .ctl_rst_req(ctl_rst_req), .ctl_up_flush(ctl_up_flush),
    .ctl_up_eot_ack(ctl_up_eot_ack), .host_rst_req(host_rst_req)
  );

  int checks = 0, errors = 0;
  logic [32:0] up_q[$];
  logic [32:0] dn_q[$];
  logic up_deot = 0, dn_deot = 0, up_h = 0, dn_h = 0, up_c = 0, dn_c = 0;

  function automatic logic [31:0] exp_status(input bit dn);
    logic [31:0] s;
    int n;
    s = '0;
    n = dn ? dn_q.size() : up_q.size();
    s[25] = dn ? dn_h : up_h;
    s[24] = dn ? dn_c : up_c;
    s[23] = dn ? dn_deot : up_deot;
    s[21] = (n == 8);
    s[20] = (n == 0);
    s[19:16] = 4'(n);
    for (int i = 0; i < n; i++) begin
      s[8+i] = 1'b1;
      s[i]   = dn ? dn_q[i][32] : up_q[i][32];
    end
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check_all();
    reg_addr = 8'h04; #1;
    chk("R3 R4 R10 outbound status", reg_rdata, exp_status(1'b0));
    reg_addr = 8'h44; #1;
    chk("R3 R4 R10 return status", reg_rdata, exp_status(1'b1));
    chk("R8 host_rst_req", {31'b0, host_rst_req}, {31'b0, up_h});
    chk("R6 dn_ready", {31'b0, dn_ready}, {31'b0, dn_q.size() < 8});
    chk("R1 up_valid", {31'b0, up_valid}, {31'b0, up_q.size() != 0});
    if (up_q.size() != 0) begin
      chk("R1 R11 up_data", up_data, up_q[0][31:0]);
      chk("R1 up_eot", {31'b0, up_eot}, {31'b0, up_q[0][32]});
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
    case (a)
      8'h00: if (up_q.size() < 8) up_q.push_back({1'b0, d});
      8'h08: if (d[31] && up_q.size() < 8) up_q.push_back({1'b1, 32'h0});
      8'h0C: if (d[31]) begin up_h = 1; dn_h = 1; end
      8'h50: if (d[31]) begin dn_q.delete(); dn_deot = 0; dn_h = 0; dn_c = 0; end
      8'h54: if (d[31]) dn_deot = 0;
      default: ;
    endcase
  endtask

  task automatic host_rd_dn();
    reg_addr = 8'h40; reg_rd = 1'b1; #1;
    chk("R2 data-out read", reg_rdata, (dn_q.size() != 0) ? dn_q[0][31:0] : 32'h0);
    tick();
    reg_rd = 1'b0;
    if (dn_q.size() != 0) begin
      if (dn_q[0][32]) dn_deot = 1;
      void'(dn_q.pop_front());
    end
  endtask

  task automatic ctl_pop();
    up_ready = 1'b1;
    tick();
    up_ready = 1'b0;
    if (up_q.size() != 0) begin
      if (up_q[0][32]) up_deot = 1;
      void'(up_q.pop_front());
    end
  endtask

  task automatic ctl_push(input logic [31:0] d, input logic e);
    dn_valid = 1'b1; dn_data = d; dn_eot = e;
    tick();
    dn_valid = 1'b0;
    if (dn_q.size() < 8) dn_q.push_back({e, d});
  endtask

  task automatic ctl_pulse(input int which);
    case (which)
      0: ctl_rst_req = 1'b1;
      1: ctl_up_flush = 1'b1;
      default: ctl_up_eot_ack = 1'b1;
    endcase
    tick();
    ctl_rst_req = 0; ctl_up_flush = 0; ctl_up_eot_ack = 0;
    case (which)
      0: begin up_c = 1; dn_c = 1; end
      1: begin up_q.delete(); up_deot = 0; up_h = 0; up_c = 0; end
      default: up_deot = 0;
    endcase
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R3: reset state of both status words
    check_all();

    // R1 R4 R5: mixed words and a marker, then a marker write without bit 31
    host_wr(8'h00, 32'h1111_0001); host_wr(8'h08, 32'h8000_0000);
    host_wr(8'h00, 32'h2222_0002); check_all();
    host_wr(8'h08, 32'h7FFF_FFFF); check_all();

    // R6: fill to eight, one more dropped
    for (int i = 0; i < 6; i++) host_wr(8'h00, 32'hA000_0000 + i);
    check_all();
    host_wr(8'h00, 32'hDEAD_BEEF); check_all();
    host_wr(8'h08, 32'h8000_0000); check_all();

    // R11: stall with a word pending
    for (int i = 0; i < 3; i++) begin tick(); check_all(); end

    // R1 R7: drain, consumed flag, acknowledge
    for (int i = 0; i < 3; i++) begin ctl_pop(); check_all(); end
    ctl_pulse(2); check_all();

    // R2: empty read returns zero
    host_rd_dn(); check_all();

    // R2 R6 R7: return queue over full, reads, acknowledge
    for (int i = 0; i < 9; i++) begin ctl_push(32'hB000_0000 + i, i[0]); check_all(); end
    host_rd_dn(); host_rd_dn(); check_all();
    host_wr(8'h54, 32'h8000_0000); check_all();

    // R8 R9: requests then resets of each queue
    host_wr(8'h0C, 32'h8000_0000); ctl_pulse(0); check_all();
    ctl_pulse(1); check_all();
    host_wr(8'h50, 32'h8000_0000); check_all();

    // Random mix
    for (int n = 0; n < 2500; n++) begin
      int op;
      op = $urandom_range(0, 19);
      case (op)
        0, 1, 2, 3: host_wr(8'h00, $urandom());
        4:          host_wr(8'h08, {$urandom_range(0, 1) == 1, 31'h0});
        5, 6, 7:    ctl_pop();
        8, 9, 10, 11: ctl_push($urandom(), $urandom_range(0, 3) == 0);
        12, 13, 14: host_rd_dn();
        15:         host_wr(8'h54, {$urandom_range(0, 1) == 1, 31'h0});
        16:         ctl_pulse(2);
        17:         if ($urandom_range(0, 7) == 0) ctl_pulse($urandom_range(0, 1)); else tick();
        18:         if ($urandom_range(0, 7) == 0) host_wr(8'h50, 32'h8000_0000);
                    else host_wr(8'h0C, {$urandom_range(0, 3) == 0, 31'h0});
        default:    tick();
      endcase
      check_all();
    end
    finish_run();
  end
endmodule